// File: doc/BRIEF.md
# BCD Time-of-Day Calendar with Write Sanitizing

This block holds the current date and time as packed two-digit BCD fields: year, month, day, day of week, hour, minute and second. Each pulse on a one-per-second tick input moves the time forward. The block handles month lengths and leap years for years 00 to 99, which cover 2000 to 2099. Year 99 wraps to 00. The day-of-week counter runs on its own and steps once each time the day rolls over. The hour can be coded either way. In 24-hour mode it runs 00 to 23. In 12-hour mode it runs 00 to 11 with a separate PM flag.

Software loads every field at once through a parallel write port. The block checks each field in the same cycle it is loaded. A value that is not legal BCD, or that lies outside the field's range, is replaced by a fixed default. When the seconds roll from 59 to 00, the block pulses a minute-carry strobe for one cycle. Neighbouring interrupt logic uses this strobe.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read year 00, month 01, day 01, day of week 0, hour 00, PM 0, minute 00, second 00, and the minute carry is low.
- R2: Each tick advances the seconds by one in BCD. Seconds roll 59 to 00 and carry into the minutes, and minutes roll 59 to 00 and carry into the hour. `minuteCarry` is high for exactly the one cycle in which the second reads 00 after such a roll. With no tick and no write, no field changes.
- R3: The day rolls to 01 after the last day of the month. Months 01, 03, 05, 07, 08, 10 and 12 have 31 days, and months 04, 06, 09 and 11 have 30 days.
- R4: February has 29 days when the year value is divisible by 4 (00 counts as divisible) and 28 days otherwise.
- R5: Month 12 rolls to 01 and steps the year. Year 99 steps to 00.
- R6: The day of week (0 is Sunday, legal values 0 to 6) steps once per day rollover and wraps from 6 to 0, whatever the date is.
- R7: On a write, a year with either digit above 9 becomes 00. A month that is 00, above 12, or has a digit above 9 becomes 01. A day that is 00, above 31, or has a digit above 9 becomes 01.
- R8: On a write, a day of week of 7 becomes 0. A minute or second above 59, or with a digit above 9, becomes 00.
- R9: On a write in 24-hour mode (`mode24`=1), an hour above 23 or with a digit above 9 becomes 00. In 12-hour mode (`mode24`=0), an hour above 11 or with a digit above 9 becomes 00.
- R10: In 12-hour mode, `pm` returns the written PM flag. 11 AM steps to 00 PM on the same day, and 11 PM steps to 00 AM with a day rollover. In 24-hour mode the written PM flag is ignored, and `pm` reads 1 for hours 12 to 23 and 0 for hours 00 to 11.
- R11: After the seconds are rewritten, counting continues from the written value. For example, writing 57 gives the minute carry on the third tick.
- R12: A write in the same cycle as a tick wins: the fields take the sanitized written values and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse once per second |
| wrEn | input | 1 | Load all write fields this cycle |
| mode24 | input | 1 | 1: 24-hour coding, 0: 12-hour coding |
| wrYear | input | 8 | Year to write, BCD |
| wrMonth | input | 8 | Month to write, BCD |
| wrDay | input | 8 | Day to write, BCD |
| wrWeekday | input | 3 | Day of week to write |
| wrHour | input | 8 | Hour to write, BCD |
| wrPm | input | 1 | PM flag to write (12-hour mode only) |
| wrMinute | input | 8 | Minute to write, BCD |
| wrSecond | input | 8 | Second to write, BCD |
| year | output | 8 | Current year, BCD |
| month | output | 8 | Current month, BCD |
| day | output | 8 | Current day, BCD |
| weekday | output | 3 | Current day of week |
| hour | output | 8 | Current hour, BCD |
| pm | output | 1 | PM indication |
| minute | output | 8 | Current minute, BCD |
| second | output | 8 | Current second, BCD |
| minuteCarry | output | 1 | One-cycle strobe on the seconds 59 to 00 roll |

## Verification
The bench builds the block with its default last weekday value of 6, so the day-of-week wrap at 6 and the sanitizing of 7 are both reachable. Because the write port loads every field at once, the bench can place the time one tick before any rollover. Month ends, leap and non-leap Februaries, the year 99 wrap and both AM/PM transitions are therefore each reached in a single tick. Together they take only a few hundred cycles instead of simulated days.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int BCD_W = 8;
  localparam int WD_W  = 3;

  typedef struct packed {
    logic [BCD_W-1:0] year;
    logic [BCD_W-1:0] month;
    logic [BCD_W-1:0] day;
    logic [WD_W-1:0]  weekday;
    logic [BCD_W-1:0] hour;
    logic             pm;
    logic [BCD_W-1:0] minute;
    logic [BCD_W-1:0] second;
  } calTime_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic stepSec;
    logic stepMin;
    logic stepHour;
    logic flipPm;
    logic stepDay;
    logic stepMonth;
    logic stepYear;
  } calStep_t;

  function automatic logic isBcd(input logic [BCD_W-1:0] v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  // BCD increment, 99 wraps to 00
  function automatic logic [BCD_W-1:0] bcdNext(input logic [BCD_W-1:0] v);
    if (v[3:0] == 4'd9)
      return (v[7:4] == 4'd9) ? 8'h00 : {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic isLeap(input logic [BCD_W-1:0] y);
    logic [6:0] bin;
    bin = 7'({3'b000, y[7:4]} * 7'd10) + {3'b000, y[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  // last day of a month, BCD
  function automatic logic [BCD_W-1:0] lastDay(input logic [BCD_W-1:0] m,
                                               input logic [BCD_W-1:0] y);
    case (m)
      8'h02:                      return isLeap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_sanitize.sv
module cal_sanitize
  import cal_pkg::*;
#(
  parameter int LAST_WEEKDAY = 6
) (
  input  calTime_t raw,
  input  logic     mode24,
  output calTime_t clean
);

  logic yearOk, monthOk, dayOk, wdOk, hourOk, minOk, secOk;

  always_comb begin
    yearOk  = isBcd(raw.year);
    monthOk = isBcd(raw.month) && (raw.month != 8'h00) && (raw.month <= 8'h12);
    dayOk   = isBcd(raw.day) && (raw.day != 8'h00) && (raw.day <= 8'h31);
    wdOk    = int'(raw.weekday) <= LAST_WEEKDAY;
    minOk   = isBcd(raw.minute) && (raw.minute <= 8'h59);
    secOk   = isBcd(raw.second) && (raw.second <= 8'h59);
    hourOk  = isBcd(raw.hour) && (mode24 ? (raw.hour <= 8'h23) : (raw.hour <= 8'h11));

    clean.year    = yearOk  ? raw.year    : 8'h00;
    clean.month   = monthOk ? raw.month   : 8'h01;
    clean.day     = dayOk   ? raw.day     : 8'h01;
    clean.weekday = wdOk    ? raw.weekday : '0;
    clean.hour    = hourOk  ? raw.hour    : 8'h00;
    clean.minute  = minOk   ? raw.minute  : 8'h00;
    clean.second  = secOk   ? raw.second  : 8'h00;
    clean.pm      = mode24 ? 1'b0 : raw.pm;
  end

endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
(
  input  logic     tick,
  input  logic     wrEn,
  input  logic     mode24,
  input  calTime_t cur,
  output calStep_t step
);

  logic secEnd, minEnd, hourEnd, dayEnd, monthEnd, advance;

  always_comb begin
    secEnd   = cur.second == 8'h59;
    minEnd   = cur.minute == 8'h59;
    hourEnd  = mode24 ? (cur.hour == 8'h23) : ((cur.hour == 8'h11) && cur.pm);
    dayEnd   = cur.day >= lastDay(cur.month, cur.year);
    monthEnd = cur.month == 8'h12;
    advance  = tick && !wrEn;

    step.load      = wrEn;
    step.stepSec   = advance;
    step.stepMin   = advance && secEnd;
    step.stepHour  = step.stepMin && minEnd;
    step.flipPm    = step.stepHour && !mode24 && (cur.hour == 8'h11);
    step.stepDay   = step.stepHour && hourEnd;
    step.stepMonth = step.stepDay && dayEnd;
    step.stepYear  = step.stepMonth && monthEnd;
  end

endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int LAST_WEEKDAY = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  calStep_t step,
  input  calTime_t clean,
  output calTime_t cur,
  output logic     minuteCarry
);

  localparam logic [WD_W-1:0] WD_LAST = WD_W'(LAST_WEEKDAY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur.year    <= 8'h00;
      cur.month   <= 8'h01;
      cur.day     <= 8'h01;
      cur.weekday <= '0;
      cur.hour    <= 8'h00;
      cur.pm      <= 1'b0;
      cur.minute  <= 8'h00;
      cur.second  <= 8'h00;
      minuteCarry <= 1'b0;
    end else begin
      minuteCarry <= step.stepMin;
      if (step.load) begin
        cur <= clean;
      end else begin
        if (step.stepSec)
          cur.second <= step.stepMin ? 8'h00 : bcdNext(cur.second);
        if (step.stepMin)
          cur.minute <= step.stepHour ? 8'h00 : bcdNext(cur.minute);
        if (step.stepHour)
          cur.hour <= (step.stepDay || step.flipPm) ? 8'h00 : bcdNext(cur.hour);
        if (step.flipPm)
          cur.pm <= !cur.pm;
        if (step.stepDay) begin
          cur.day     <= step.stepMonth ? 8'h01 : bcdNext(cur.day);
          cur.weekday <= (cur.weekday >= WD_LAST) ? '0 : cur.weekday + 1'b1;
        end
        if (step.stepMonth)
          cur.month <= step.stepYear ? 8'h01 : bcdNext(cur.month);
        if (step.stepYear)
          cur.year <= bcdNext(cur.year);
      end
    end
  end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int LAST_WEEKDAY = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wrEn,
  input  logic       mode24,
  input  logic [7:0] wrYear,
  input  logic [7:0] wrMonth,
  input  logic [7:0] wrDay,
  input  logic [2:0] wrWeekday,
  input  logic [7:0] wrHour,
  input  logic       wrPm,
  input  logic [7:0] wrMinute,
  input  logic [7:0] wrSecond,
  output logic [7:0] year,
  output logic [7:0] month,
  output logic [7:0] day,
  output logic [2:0] weekday,
  output logic [7:0] hour,
  output logic       pm,
  output logic [7:0] minute,
  output logic [7:0] second,
  output logic       minuteCarry
);

  calTime_t raw, clean, cur;
  calStep_t step;

  always_comb begin
    raw.year    = wrYear;
    raw.month   = wrMonth;
    raw.day     = wrDay;
    raw.weekday = wrWeekday;
    raw.hour    = wrHour;
    raw.pm      = wrPm;
    raw.minute  = wrMinute;
    raw.second  = wrSecond;
  end

  cal_sanitize #(.LAST_WEEKDAY(LAST_WEEKDAY)) u_san (
    .raw(raw), .mode24(mode24), .clean(clean)
  );

  cal_ctrl u_ctrl (
    .tick(tick), .wrEn(wrEn), .mode24(mode24), .cur(cur), .step(step)
  );

  cal_datapath #(.LAST_WEEKDAY(LAST_WEEKDAY)) u_dp (
    .clk(clk), .rst_n(rst_n), .step(step), .clean(clean),
    .cur(cur), .minuteCarry(minuteCarry)
  );

  assign year    = cur.year;
  assign month   = cur.month;
  assign day     = cur.day;
  assign weekday = cur.weekday;
  assign hour    = cur.hour;
  assign minute  = cur.minute;
  assign second  = cur.second;
  assign pm      = mode24 ? (cur.hour >= 8'h12) : cur.pm;

endmodule

// File: rtl/cal_checker.sv
module cal_checker #(
  parameter int LAST_WEEKDAY = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wrEn,
  input logic       mode24,
  input logic [7:0] year,
  input logic [7:0] month,
  input logic [7:0] day,
  input logic [2:0] weekday,
  input logic [7:0] hour,
  input logic       pm,
  input logic [7:0] minute,
  input logic [7:0] second,
  input logic       minuteCarry
);

  p_carry_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    minuteCarry |-> (second == 8'h00) && $past(tick) && !$past(wrEn));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wrEn) |=> $stable({year, month, day, weekday, hour, minute, second}));

  p_month_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (month != 8'h00) && (month <= 8'h12) && (month[3:0] <= 4'd9));

  p_day_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (day != 8'h00) && (day <= 8'h31) && (day[3:0] <= 4'd9));

  p_second_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (second <= 8'h59) && (second[3:0] <= 4'd9));

  p_weekday_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(weekday) <= LAST_WEEKDAY);

  p_hour_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hour <= 8'h23) && (hour[3:0] <= 4'd9));

  p_pm_derived_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode24 |-> (pm == (hour >= 8'h12)));

endmodule

bind bcd_calendar cal_checker #(.LAST_WEEKDAY(LAST_WEEKDAY)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wrEn(wrEn), .mode24(mode24),
  .year(year), .month(month), .day(day), .weekday(weekday), .hour(hour),
  .pm(pm), .minute(minute), .second(second), .minuteCarry(minuteCarry)
);

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wrEn = 1'b0, mode24 = 1'b1, wrPm = 1'b0;
  logic [7:0] wrYear = '0, wrMonth = '0, wrDay = '0, wrHour = '0, wrMinute = '0, wrSecond = '0;
  logic [2:0] wrWeekday = '0;
  logic [7:0] year, month, day, hour, minute, second;
  logic [2:0] weekday;
  logic pm, minuteCarry;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_calendar u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrEn(wrEn), .mode24(mode24),
    .wrYear(wrYear), .wrMonth(wrMonth), .wrDay(wrDay), .wrWeekday(wrWeekday),
    .wrHour(wrHour), .wrPm(wrPm), .wrMinute(wrMinute), .wrSecond(wrSecond),
    .year(year), .month(month), .day(day), .weekday(weekday), .hour(hour),
    .pm(pm), .minute(minute), .second(second), .minuteCarry(minuteCarry)
  );

  typedef struct {
    string      req;
    logic [7:0] y, mo, d;
    logic [2:0] wd;
    logic [7:0] h;
    logic       p;
    logic [7:0] mi, s;
    logic       c;
  } expItem_t;

  expItem_t expQ[$];

  // monitor: compares one expected item per cycle, away from the rising edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      logic [52:0] got, want;
      it = expQ.pop_front();
      got  = {year, month, day, weekday, hour, pm, minute, second, minuteCarry};
      want = {it.y, it.mo, it.d, it.wd, it.h, it.p, it.mi, it.s, it.c};
      checks++;
      if (got !== want) begin
        fails++;
        $display("FAIL %s: got y%h mo%h d%h wd%0d h%h pm%b mi%h s%h c%b, expected y%h mo%h d%h wd%0d h%h pm%b mi%h s%h c%b",
                 it.req, year, month, day, weekday, hour, pm, minute, second, minuteCarry,
                 it.y, it.mo, it.d, it.wd, it.h, it.p, it.mi, it.s, it.c);
      end
    end
  end

  task automatic expectNow(input string req, input logic [7:0] y, mo, d,
                           input logic [2:0] wd, input logic [7:0] h, input logic p,
                           input logic [7:0] mi, s, input logic c);
    expItem_t it;
    it.req = req; it.y = y; it.mo = mo; it.d = d; it.wd = wd;
    it.h = h; it.p = p; it.mi = mi; it.s = s; it.c = c;
    expQ.push_back(it);
  endtask

  task automatic writeAll(input logic [7:0] y, mo, d, input logic [2:0] wd,
                          input logic [7:0] h, input logic p, input logic [7:0] mi, s,
                          input logic m24, input logic withTick);
    @(negedge clk); #2;
    wrYear = y; wrMonth = mo; wrDay = d; wrWeekday = wd; wrHour = h;
    wrPm = p; wrMinute = mi; wrSecond = s; mode24 = m24;
    wrEn = 1'b1; tick = withTick;
    @(posedge clk); #1;
    wrEn = 1'b0; tick = 1'b0;
  endtask

  task automatic tickOnce();
    @(negedge clk); #2;
    tick = 1'b1;
    @(posedge clk); #1;
    tick = 1'b0;
  endtask

  task automatic idleOnce();
    @(negedge clk); #2;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #2 rst_n = 1'b1;
    @(posedge clk); #1;
    expectNow("R1 reset", 8'h00, 8'h01, 8'h01, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);

    // R10: 24-hour mode ignores written PM, derives it from hour
    writeAll(8'h23, 8'h12, 8'h31, 3'd6, 8'h23, 1'b0, 8'h59, 8'h58, 1'b1, 1'b0);
    expectNow("R10 pm24", 8'h23, 8'h12, 8'h31, 3'd6, 8'h23, 1'b1, 8'h59, 8'h58, 1'b0);
    tickOnce();
    expectNow("R2 count", 8'h23, 8'h12, 8'h31, 3'd6, 8'h23, 1'b1, 8'h59, 8'h59, 1'b0);
    tickOnce();
    expectNow("R2 R5 R6 newyear", 8'h24, 8'h01, 8'h01, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
    idleOnce();
    expectNow("R2 carry single", 8'h24, 8'h01, 8'h01, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);

    // R4 leap February
    writeAll(8'h24, 8'h02, 8'h28, 3'd3, 8'h23, 1'b0, 8'h59, 8'h59, 1'b1, 1'b0);
    tickOnce();
    expectNow("R4 leap 28", 8'h24, 8'h02, 8'h29, 3'd4, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
    tickOnce();
    expectNow("R2 next sec", 8'h24, 8'h02, 8'h29, 3'd4, 8'h00, 1'b0, 8'h00, 8'h01, 1'b0);
    writeAll(8'h24, 8'h02, 8'h29, 3'd4, 8'h23, 1'b0, 8'h59, 8'h59, 1'b1, 1'b0);
    tickOnce();
    expectNow("R4 leap 29", 8'h24, 8'h03, 8'h01, 3'd5, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
    writeAll(8'h23, 8'h02, 8'h28, 3'd1, 8'h23, 1'b0, 8'h59, 8'h59, 1'b1, 1'b0);
    tickOnce();
    expectNow("R4 nonleap", 8'h23, 8'h03, 8'h01, 3'd2, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
    writeAll(8'h00, 8'h02, 8'h28, 3'd1, 8'h23, 1'b0, 8'h59, 8'h59, 1'b1, 1'b0);
    tickOnce();
    expectNow("R4 year00", 8'h00, 8'h02, 8'h29, 3'd2, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);

    // R3 month lengths
    writeAll(8'h23, 8'h04, 8'h30, 3'd0, 8'h23, 1'b0, 8'h59, 8'h59, 1'b1, 1'b0);
    tickOnce();
    expectNow("R3 april", 8'h23, 8'h05, 8'h01, 3'd1, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
    writeAll(8'h23, 8'h07, 8'h31, 3'd0, 8'h23, 1'b0, 8'h59, 8'h59, 1'b1, 1'b0);
    tickOnce();
    expectNow("R3 july", 8'h23, 8'h08, 8'h01, 3'd1, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
    writeAll(8'h23, 8'h08, 8'h30, 3'd0, 8'h23, 1'b0, 8'h59, 8'h59, 1'b1, 1'b0);
    tickOnce();
    expectNow("R3 august30", 8'h23, 8'h08, 8'h31, 3'd1, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
    writeAll(8'h23, 8'h11, 8'h30, 3'd6, 8'h23, 1'b0, 8'h59, 8'h59, 1'b1, 1'b0);
    tickOnce();
    expectNow("R3 R6 november", 8'h23, 8'h12, 8'h01, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);

    // R5 year wrap
    writeAll(8'h99, 8'h12, 8'h31, 3'd5, 8'h23, 1'b0, 8'h59, 8'h59, 1'b1, 1'b0);
    tickOnce();
    expectNow("R5 year99", 8'h00, 8'h01, 8'h01, 3'd6, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);

    // R7 R8 R9 sanitizing in 24-hour mode
    writeAll(8'h9A, 8'h13, 8'h00, 3'd7, 8'h24, 1'b0, 8'h60, 8'h7F, 1'b1, 1'b0);
    expectNow("R7 R8 R9 bad1", 8'h00, 8'h01, 8'h01, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
    writeAll(8'hA5, 8'h1A, 8'h32, 3'd5, 8'h3F, 1'b0, 8'h5A, 8'h59, 1'b1, 1'b0);
    expectNow("R7 R8 R9 bad2", 8'h00, 8'h01, 8'h01, 3'd5, 8'h00, 1'b0, 8'h00, 8'h59, 1'b0);
    writeAll(8'h45, 8'h10, 8'h19, 3'd2, 8'h29, 1'b0, 8'h79, 8'h60, 1'b1, 1'b0);
    expectNow("R7 R8 R9 bad3", 8'h45, 8'h10, 8'h19, 3'd2, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);

    // R10 ignored PM, R11 rewritten seconds
    writeAll(8'h45, 8'h10, 8'h19, 3'd2, 8'h05, 1'b1, 8'h10, 8'h57, 1'b1, 1'b0);
    expectNow("R10 pm ignored", 8'h45, 8'h10, 8'h19, 3'd2, 8'h05, 1'b0, 8'h10, 8'h57, 1'b0);
    tickOnce();
    expectNow("R11 tick1", 8'h45, 8'h10, 8'h19, 3'd2, 8'h05, 1'b0, 8'h10, 8'h58, 1'b0);
    tickOnce();
    expectNow("R11 tick2", 8'h45, 8'h10, 8'h19, 3'd2, 8'h05, 1'b0, 8'h10, 8'h59, 1'b0);
    tickOnce();
    expectNow("R11 tick3 carry", 8'h45, 8'h10, 8'h19, 3'd2, 8'h05, 1'b0, 8'h11, 8'h00, 1'b1);

    // R12 write beats tick
    writeAll(8'h45, 8'h10, 8'h19, 3'd2, 8'h05, 1'b0, 8'h10, 8'h30, 1'b1, 1'b1);
    expectNow("R12 write wins", 8'h45, 8'h10, 8'h19, 3'd2, 8'h05, 1'b0, 8'h10, 8'h30, 1'b0);

    // 12-hour mode
    writeAll(8'h45, 8'h10, 8'h19, 3'd2, 8'h12, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
    expectNow("R9 h12 bad12", 8'h45, 8'h10, 8'h19, 3'd2, 8'h00, 1'b1, 8'h00, 8'h00, 1'b0);
    writeAll(8'h45, 8'h10, 8'h19, 3'd2, 8'h20, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0);
    expectNow("R9 h12 bad20", 8'h45, 8'h10, 8'h19, 3'd2, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0);
    writeAll(8'h45, 8'h10, 8'h19, 3'd2, 8'h0B, 1'b1, 8'h00, 8'h00, 1'b0, 1'b0);
    expectNow("R9 h12 badB", 8'h45, 8'h10, 8'h19, 3'd2, 8'h00, 1'b1, 8'h00, 8'h00, 1'b0);
    writeAll(8'h45, 8'h10, 8'h19, 3'd2, 8'h11, 1'b1, 8'h59, 8'h59, 1'b0, 1'b0);
    expectNow("R9 R10 h11pm kept", 8'h45, 8'h10, 8'h19, 3'd2, 8'h11, 1'b1, 8'h59, 8'h59, 1'b0);
    tickOnce();
    expectNow("R10 pm to am", 8'h45, 8'h10, 8'h20, 3'd3, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
    writeAll(8'h45, 8'h10, 8'h20, 3'd3, 8'h11, 1'b0, 8'h59, 8'h59, 1'b0, 1'b0);
    tickOnce();
    expectNow("R10 am to pm", 8'h45, 8'h10, 8'h20, 3'd3, 8'h00, 1'b1, 8'h00, 8'h00, 1'b1);

    idleOnce();
    idleOnce();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule